// File: doc/BRIEF.md
# Branch and Skip Resolver

This unit decides where the program counter of a small 8-bit core goes after a control-flow instruction, and how many cycles that instruction uses. The decoder gives it a request with an operation code, the current PC, a signed relative offset, the status byte, a selected status bit index, a wanted polarity, a single tested bit, two register operands for equality compare, the 16-bit indirect pointer, and a flag that says whether the instruction after the current one is two words long.

Each request is resolved in one registered stage. The result gives the next PC, a taken flag and a cycle count of 1, 2 or 3. Conditional branches can test any status bit, or the signed "less than" term formed by the N and V bits. Skips test either a register or I/O bit, or the equality of two registers. Jumps are either relative or indirect through the pointer. All PC arithmetic wraps modulo the program memory depth of 2^PC_W words. The default depth is 512 words.

Top module: `flow_resolver`

## Requirements
- R1: While reset is held, and in the first cycle after it, res_valid, res_pc, res_taken and res_cycles are all zero.
- R2: A result appears exactly one clock after the request edge. res_valid is high in a cycle if and only if req_valid was high at the previous edge. When no request is present, res_pc, res_taken and res_cycles keep their last values.
- R3: Op 0 is the generic branch. It is taken when status[status_sel] equals want_set. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6 and I=7. When taken, res_pc = cur_pc + rel_off + 1 (rel_off signed) and res_cycles = 2. When not taken, res_pc = cur_pc + 1 and res_cycles = 1.
- R4: Op 1 is the signed branch. It is taken when (status[2] XOR status[3]) equals want_set. want_set=1 means less-than and want_set=0 means greater-or-equal. The PC and cycle results follow R3.
- R5: The unsigned compare branches use op 0 with status_sel=0. want_set=0 gives same-or-higher and is taken when C is 0. want_set=1 gives lower and is taken when C is 1.
- R6: Op 2 is skip on a bit. It skips when probe_bit equals want_set. A skip gives res_pc = cur_pc + 2 with 2 cycles when next_is_long=0, or cur_pc + 3 with 3 cycles when next_is_long=1. When it does not skip, res_pc = cur_pc + 1 with 1 cycle.
- R7: Op 3 is compare and skip. It skips when cmp_a equals cmp_b, and the PC and cycle results follow R6.
- R8: Op 4 is the relative jump. It is always taken, with res_pc = cur_pc + rel_off + 1 and 2 cycles.
- R9: Op 5 is the indirect jump. It is always taken, with res_pc equal to the low PC_W bits of z_ptr and 2 cycles.
- R10: Every computed PC wraps modulo 2^PC_W, both forward past the top of memory and backward below zero.
- R11: next_is_long has no effect on ops 0, 1, 4 and 5.
- R12: Op codes 6 and 7 are not taken, with res_pc = cur_pc + 1 and 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 to 5 as in R3 to R9) |
| cur_pc | input | PC_W | PC of the current instruction, in words |
| rel_off | input | OFF_W | Signed relative offset in words |
| status | input | 8 | Status byte |
| status_sel | input | 3 | Status bit index used by op 0 |
| want_set | input | 1 | Polarity that makes the condition true |
| probe_bit | input | 1 | Register or I/O bit tested by op 2 |
| cmp_a | input | DW | First compare operand |
| cmp_b | input | DW | Second compare operand |
| z_ptr | input | Z_W | Indirect jump pointer |
| next_is_long | input | 1 | The following instruction is two words long |
| res_valid | output | 1 | Result valid |
| res_pc | output | PC_W | Next PC |
| res_taken | output | 1 | Branch, skip or jump was taken |
| res_cycles | output | 2 | Cycles used (1, 2 or 3) |

## Verification
Two functions can act on the same request: a taken transfer and the wrap of the PC. A relative branch or jump can cross the top or the bottom of memory, and a skip of a two-word instruction can start on the last words of memory. The bench provokes both directly, using PCs close to 511 and 0 together with positive and negative offsets and the long-skip flag. It judges the results against a reference model that works in plain integers and reduces the result modulo the depth. The same model is compared on every clock during a long pseudo-random run that mixes all op codes and polarities.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        FL_BRANCH    = 3'd0,
        FL_BR_SIGNED = 3'd1,
        FL_SKIP_BIT  = 3'd2,
        FL_SKIP_EQ   = 3'd3,
        FL_JUMP_REL  = 3'd4,
        FL_JUMP_IND  = 3'd5
    } flow_op_e;

    // status byte bit positions used by the signed branch
    localparam int SR_N = 2;
    localparam int SR_V = 3;

    localparam logic [1:0] CYC_ONE   = 2'd1;
    localparam logic [1:0] CYC_TWO   = 2'd2;
    localparam logic [1:0] CYC_THREE = 2'd3;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_pkg::*;
#(
    parameter int DW = 8
) (
    input  flow_op_e        op,
    input  logic [7:0]      sreg,
    input  logic [2:0]      sel,
    input  logic            pol,
    input  logic            tbit,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic            hit
);

    logic lt_term;

    always_comb begin
        lt_term = sreg[SR_N] ^ sreg[SR_V];
        case (op)
            FL_BRANCH:    hit = (sreg[sel] == pol);
            FL_BR_SIGNED: hit = (lt_term == pol);
            FL_SKIP_BIT:  hit = (tbit == pol);
            FL_SKIP_EQ:   hit = (opa == opb);
            FL_JUMP_REL,
            FL_JUMP_IND:  hit = 1'b1;
            default:      hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/flow_target_calc.sv
module flow_target_calc
    import flow_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int OFF_W = 12,
    parameter int Z_W   = 16
) (
    input  flow_op_e          op,
    input  logic [PC_W-1:0]   pc,
    input  logic [OFF_W-1:0]  off,
    input  logic [Z_W-1:0]    zp,
    input  logic              long_next,
    input  logic              hit,
    output logic [PC_W-1:0]   nxt_pc,
    output logic              taken,
    output logic [1:0]        cyc
);

    localparam int EXT_W = (OFF_W > PC_W) ? OFF_W : PC_W;

    logic signed [EXT_W-1:0] off_ext;
    logic [PC_W-1:0]         pc_seq;
    logic [PC_W-1:0]         pc_rel;
    logic [PC_W-1:0]         pc_skip;
    logic [PC_W-1:0]         pc_ind;

    always_comb begin
        off_ext = EXT_W'($signed(off));
        pc_seq  = pc + PC_W'(1);
        pc_rel  = pc + off_ext[PC_W-1:0] + PC_W'(1);
        pc_skip = pc + (long_next ? PC_W'(3) : PC_W'(2));
        pc_ind  = zp[PC_W-1:0];

        case (op)
            FL_BRANCH, FL_BR_SIGNED: begin
                taken  = hit;
                nxt_pc = hit ? pc_rel : pc_seq;
                cyc    = hit ? CYC_TWO : CYC_ONE;
            end
            FL_SKIP_BIT, FL_SKIP_EQ: begin
                taken  = hit;
                nxt_pc = hit ? pc_skip : pc_seq;
                cyc    = hit ? (long_next ? CYC_THREE : CYC_TWO) : CYC_ONE;
            end
            FL_JUMP_REL: begin
                taken  = 1'b1;
                nxt_pc = pc_rel;
                cyc    = CYC_TWO;
            end
            FL_JUMP_IND: begin
                taken  = 1'b1;
                nxt_pc = pc_ind;
                cyc    = CYC_TWO;
            end
            default: begin
                taken  = 1'b0;
                nxt_pc = pc_seq;
                cyc    = CYC_ONE;
            end
        endcase
    end

endmodule

// File: rtl/flow_resolver.sv
module flow_resolver
    import flow_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int OFF_W = 12,
    parameter int Z_W   = 16,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [7:0]        status,
    input  logic [2:0]        status_sel,
    input  logic              want_set,
    input  logic              probe_bit,
    input  logic [DW-1:0]     cmp_a,
    input  logic [DW-1:0]     cmp_b,
    input  logic [Z_W-1:0]    z_ptr,
    input  logic              next_is_long,
    output logic              res_valid,
    output logic [PC_W-1:0]   res_pc,
    output logic              res_taken,
    output logic [1:0]        res_cycles
);

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        logic            tk;
        logic [1:0]      cyc;
    } res_t;

    res_t            st_d, st_q;
    flow_op_e        op_dec;
    logic            cond_hit;
    logic [PC_W-1:0] calc_pc;
    logic            calc_tk;
    logic [1:0]      calc_cyc;

    assign op_dec = flow_op_e'(req_op);

    flow_cond_eval #(.DW(DW)) u_cond (
        .op   (op_dec),
        .sreg (status),
        .sel  (status_sel),
        .pol  (want_set),
        .tbit (probe_bit),
        .opa  (cmp_a),
        .opb  (cmp_b),
        .hit  (cond_hit)
    );

    flow_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .Z_W(Z_W)) u_target (
        .op        (op_dec),
        .pc        (cur_pc),
        .off       (rel_off),
        .zp        (z_ptr),
        .long_next (next_is_long),
        .hit       (cond_hit),
        .nxt_pc    (calc_pc),
        .taken     (calc_tk),
        .cyc       (calc_cyc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.pc  = calc_pc;
            st_d.tk  = calc_tk;
            st_d.cyc = calc_cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.vld;
    assign res_pc     = st_q.pc;
    assign res_taken  = st_q.tk;
    assign res_cycles = st_q.cyc;

endmodule

// File: rtl/flow_resolver_chk.sv
module flow_resolver_chk #(
    parameter int PC_W  = 9,
    parameter int OFF_W = 12,
    parameter int Z_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [PC_W-1:0]   cur_pc,
    input logic [Z_W-1:0]    z_ptr,
    input logic              next_is_long,
    input logic              res_valid,
    input logic [PC_W-1:0]   res_pc,
    input logic              res_taken,
    input logic [1:0]        res_cycles
);

    // R2
    req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    idle_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_pc) && $stable(res_cycles)));

    // R3
    branch_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> (res_cycles == (res_taken ? 2'd2 : 2'd1)));

    // R6
    skip_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2 && next_is_long) |=> (res_cycles == (res_taken ? 2'd3 : 2'd1)));

    // R8
    jump_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> (res_taken && res_cycles == 2'd2));

    // R9
    jump_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> (res_pc == $past(z_ptr[PC_W-1:0]) && res_taken));

    // R12
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[2:1] == 2'b11) |=>
            (!res_taken && res_cycles == 2'd1 && res_pc == $past(cur_pc) + PC_W'(1)));

endmodule

bind flow_resolver flow_resolver_chk #(.PC_W(PC_W), .OFF_W(OFF_W), .Z_W(Z_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .cur_pc       (cur_pc),
    .z_ptr        (z_ptr),
    .next_is_long (next_is_long),
    .res_valid    (res_valid),
    .res_pc       (res_pc),
    .res_taken    (res_taken),
    .res_cycles   (res_cycles)
);

// File: tb/flow_resolver_bench.sv
module flow_resolver_bench;

    localparam int PC_W  = 9;
    localparam int OFF_W = 12;
    localparam int Z_W   = 16;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << PC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [PC_W-1:0]   cur_pc = '0;
    logic [OFF_W-1:0]  rel_off = '0;
    logic [7:0]        status = '0;
    logic [2:0]        status_sel = '0;
    logic              want_set = 1'b0;
    logic              probe_bit = 1'b0;
    logic [DW-1:0]     cmp_a = '0;
    logic [DW-1:0]     cmp_b = '0;
    logic [Z_W-1:0]    z_ptr = '0;
    logic              next_is_long = 1'b0;
    logic              res_valid;
    logic [PC_W-1:0]   res_pc;
    logic              res_taken;
    logic [1:0]        res_cycles;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int    e_vld = 0, e_pc = 0, e_tk = 0, e_cyc = 0;
    string e_tag = "R1";

    always #5ns clk = ~clk;

    flow_resolver #(.PC_W(PC_W), .OFF_W(OFF_W), .Z_W(Z_W), .DW(DW)) u_flow_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .cur_pc(cur_pc), .rel_off(rel_off), .status(status), .status_sel(status_sel),
        .want_set(want_set), .probe_bit(probe_bit), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .z_ptr(z_ptr), .next_is_long(next_is_long), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_cycles(res_cycles)
    );

    function automatic int wrapv(int x);
        return ((x % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic compare_now();
        total++;
        if (int'(res_valid) != e_vld || int'(res_pc) != e_pc ||
            int'(res_taken) != e_tk || int'(res_cycles) != e_cyc) begin
            bad++;
            $display("FAIL %s: got vld=%0d pc=%0d tk=%0d cyc=%0d, want vld=%0d pc=%0d tk=%0d cyc=%0d",
                     e_tag, res_valid, res_pc, res_taken, res_cycles, e_vld, e_pc, e_tk, e_cyc);
        end
    endtask

    // reference model: behavioural, integer based
    task automatic model(input int op, input int pc, input int k, input int sr, input int s,
                         input int pol, input int pb, input int a, input int b, input int z,
                         input int lng);
        int cond;
        int skip_len;
        skip_len = lng ? 3 : 2;
        case (op)
            0: cond = (((sr >> s) & 1) == pol);
            1: cond = ((((sr >> 2) ^ (sr >> 3)) & 1) == pol);
            2: cond = (pb == pol);
            3: cond = (a == b);
            default: cond = 0;
        endcase
        e_vld = 1;
        if (op == 4) begin
            e_tk = 1; e_pc = wrapv(pc + k + 1); e_cyc = 2;
        end else if (op == 5) begin
            e_tk = 1; e_pc = z % DEPTH; e_cyc = 2;
        end else if (op <= 1) begin
            e_tk = cond; e_pc = cond ? wrapv(pc + k + 1) : wrapv(pc + 1); e_cyc = cond ? 2 : 1;
        end else if (op <= 3) begin
            e_tk = cond; e_pc = cond ? wrapv(pc + skip_len) : wrapv(pc + 1);
            e_cyc = cond ? skip_len : 1;
        end else begin
            e_tk = 0; e_pc = wrapv(pc + 1); e_cyc = 1;
        end
    endtask

    task automatic issue(input string tag, input int op, input int pc, input int k,
                         input int sr, input int s, input int pol, input int pb,
                         input int a, input int b, input int z, input int lng);
        @(negedge clk);
        compare_now();
        req_valid    = 1'b1;
        req_op       = 3'(op);
        cur_pc       = PC_W'(pc);
        rel_off      = OFF_W'(k);
        status       = 8'(sr);
        status_sel   = 3'(s);
        want_set     = 1'(pol);
        probe_bit    = 1'(pb);
        cmp_a        = DW'(a);
        cmp_b        = DW'(b);
        z_ptr        = Z_W'(z);
        next_is_long = 1'(lng);
        model(op, pc, k, sr, s, pol, pb, a, b, z, lng);
        e_tag = tag;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        compare_now();
        req_valid = 1'b0;
        e_vld = 0;
        e_tag = tag;
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and right after reset
        repeat (3) @(negedge clk);
        compare_now();
        rst_n = 1'b1;
        idle("R1");
        idle("R2");

        // R3: generic branch on each status bit, both polarities
        for (int s = 0; s < 8; s++) begin
            issue("R3", 0, 100, 7,  8'hA5, s, 1, 0, 0, 0, 0, 0);
            issue("R3", 0, 100, -9, 8'hA5, s, 0, 0, 0, 0, 0, 1);
        end
        // R4: signed branch, all N/V combinations
        for (int nv = 0; nv < 4; nv++) begin
            issue("R4", 1, 40, 20, nv << 2, 0, 1, 0, 0, 0, 0, 0);
            issue("R4", 1, 40, 20, nv << 2, 0, 0, 0, 0, 0, 0, 0);
        end
        // R5: same-or-higher / lower via carry
        issue("R5", 0, 200, -50, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        issue("R5", 0, 200, -50, 8'h01, 0, 0, 0, 0, 0, 0, 0);
        issue("R5", 0, 200, -50, 8'h01, 0, 1, 0, 0, 0, 0, 0);
        issue("R5", 0, 200, -50, 8'hFE, 0, 1, 0, 0, 0, 0, 0);
        // R2: gap between requests holds results
        idle("R2");
        idle("R2");
        // R6: skip on bit, short and long next instruction
        issue("R6", 2, 10, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        issue("R6", 2, 10, 0, 0, 0, 1, 1, 0, 0, 0, 1);
        issue("R6", 2, 10, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        issue("R6", 2, 10, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R7: compare and skip
        issue("R7", 3, 77, 0, 0, 0, 0, 0, 8'h3C, 8'h3C, 0, 0);
        issue("R7", 3, 77, 0, 0, 0, 0, 0, 8'h3C, 8'h3C, 0, 1);
        issue("R7", 3, 77, 0, 0, 0, 0, 0, 8'h3C, 8'h3D, 0, 1);
        // R8 / R9: jumps
        issue("R8", 4, 300, 2047, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R8", 4, 300, -2048, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R9", 5, 5, 0, 0, 0, 0, 0, 0, 0, 16'h1234, 0);
        issue("R9", 5, 5, 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 1);
        // R10: wrap forward and backward, taken transfer at the memory edge
        issue("R10", 4, 511, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R10", 4, 2, -4, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R10", 0, 510, 3, 8'h02, 1, 1, 0, 0, 0, 0, 0);
        issue("R10", 2, 510, 0, 0, 0, 1, 1, 0, 0, 0, 1);
        issue("R10", 3, 511, 0, 0, 0, 0, 0, 9, 9, 0, 0);
        issue("R10", 1, 0, -1, 8'h04, 0, 1, 0, 0, 0, 0, 0);
        issue("R10", 0, 511, 0, 8'h00, 3, 1, 0, 0, 0, 0, 0);
        // R11: long flag has no effect on branches and jumps
        issue("R11", 0, 60, 4, 8'h40, 6, 1, 0, 0, 0, 0, 1);
        issue("R11", 1, 60, 4, 8'h08, 0, 1, 0, 0, 0, 0, 1);
        issue("R11", 4, 60, 4, 0, 0, 0, 0, 0, 0, 0, 1);
        issue("R11", 5, 60, 4, 0, 0, 0, 0, 0, 0, 16'h0042, 1);
        // R12: unused op codes
        issue("R12", 6, 33, 9, 8'hFF, 0, 1, 1, 1, 1, 0, 1);
        issue("R12", 7, 511, 9, 8'hFF, 0, 1, 1, 1, 1, 0, 1);

        // mixed pseudo-random run, compared every clock
        for (int i = 0; i < 400; i++) begin
            int op;
            string tg;
            op = int'($urandom_range(0, 7));
            case (op)
                0: tg = "R3"; 1: tg = "R4"; 2: tg = "R6"; 3: tg = "R7";
                4: tg = "R8"; 5: tg = "R9"; default: tg = "R12";
            endcase
            if ((i % 13) == 0) idle("R2");
            issue(tg, op, int'($urandom_range(0, DEPTH - 1)),
                  int'($urandom_range(0, 4095)) - 2048,
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 65535)), int'($urandom_range(0, 1)));
        end
        idle("R2");
        idle("R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule